// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command-decoding and mode-control logic of a boot-block NOR flash. A host drives a simplified asynchronous-style bus (active-low chip, write and output enables, an 8-bit command/data byte and an 18-bit word address). The block samples each write cycle on the rising edge of write enable while chip enable is low. It decodes single-cycle mode commands and the two-cycle program and erase sequences. It also enforces write protection on the boot block.

Accepted operations go to a behavioural array model that stays busy for a fixed number of clock cycles and then commits. Each operation switches the read path to status mode. The read path returns array contents, the 8-bit status register or identification codes, depending on the current mode. The boot block sits at the top or at the bottom of the address space, chosen by a parameter.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The sequence 20h then D0h erases the block that holds the address of the D0h cycle. Afterwards every location of that block reads FFh, and other blocks keep their contents.
- R2: A cycle of 10h or 40h arms a program, and the next accepted write cycle supplies the address and data. When the operation completes, the location holds its old value bitwise ANDed with the data.
- R3: Command FFh selects array read mode. After a program or erase, reads return the status register until FFh is written.
- R4: On a program or erase start, the controller enters status read mode and status bit 7 (ready) reads 0. Bit 7 reads 1 again exactly BUSY_CYC clock cycles after the confirming write edge.
- R5: A program or erase aimed at the boot block is refused while both `wp` and `boot_unlock` are low. A refusal sets bit 4 (program) or bit 5 (erase), leaves the array unchanged and never goes busy. With either input high, the operation runs.
- R6: If both `wp` and `boot_unlock` fall while a boot-block operation is busy, the operation aborts without changing the array and sets its error bit.
- R7: If `vpp_ok` is low at the confirming cycle, the operation is refused and sets bit 3 plus its program or erase bit. If `vpp_ok` falls during an operation, the operation aborts with the same bits set and the array unchanged.
- R8: A second erase cycle other than D0h abandons the sequence. It sets bits 5 and 4, selects status mode and erases nothing.
- R9: With TOP_BOOT=1, the word-address blocks are 00000h-0FFFFh, 10000h-1FFFFh, 20000h-2FFFFh, 30000h-3BFFFh, 3C000h-3CFFFh, 3D000h-3DFFFh and the boot block 3E000h-3FFFFh. With TOP_BOOT=0, they are boot 00000h-01FFFh, 02000h-02FFFh, 03000h-03FFFh, 04000h-0FFFFh and then the three 64K-word blocks. Only the boot block needs unlocking. The array model keeps 2^WIN_AW words per block, selected by the low address bits.
- R10: Reset clears all error bits (status reads 80h) and selects array read mode.
- R11: The status register has ready in bit 7, erase-suspended in bit 6 (always 0), erase error in bit 5, program error in bit 4 and VPP low in bit 3. Bits 2:0 read 0. Error bits stay set until command 50h or reset. Command 70h selects status mode.
- R12: Command 90h selects identification mode. Address bit 0 low returns MFR_ID, and high returns DEV_ID_TOP or DEV_ID_BOT according to TOP_BOOT.
- R13: Write cycles that arrive while an operation is busy are ignored.
- R14: A write cycle with `ce_n` high has no effect. `dout_en` is 1 only while `ce_n` and `oe_n` are low and `we_n` is high; otherwise `dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; cycle sampled on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| din | input | 8 | Command or program data byte |
| addr | input | 18 | Word address |
| wp | input | 1 | High unlocks the boot block |
| boot_unlock | input | 1 | High unlocks the boot block (stands for the high-voltage reset level) |
| vpp_ok | input | 1 | Program/erase supply is good |
| dout | output | 8 | Read data: array, status or ID |
| dout_en | output | 1 | Read data valid and driven |

## Verification
The assertions assume that `wp`, `boot_unlock` and `vpp_ok` are ordinary synchronous levels, and that the bus holds `din` and `addr` steady across each write-enable pulse. The stimulus changes every input on the falling clock edge and keeps each enable pulse at least one full clock cycle long, so every cycle is seen as exactly one edge. The bench lowers the protection and supply inputs only during busy windows that it times from the confirming edge, so each abort lands inside a running operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W = 18;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_PROG_A      = 8'h10;
  localparam logic [7:0] CMD_PROG_B      = 8'h40;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_ID} rd_mode_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ERASE_ARM, SQ_PROG_ARM} seq_t;

  // Block number 0..6 in address order; boundaries depend on boot placement.
  function automatic logic [2:0] blk_of(input logic [ADDR_W-1:0] a, input bit top);
    logic [2:0] b;
    if (top) begin
      if (a >= 18'h3E000)      b = 3'd6;
      else if (a >= 18'h3D000) b = 3'd5;
      else if (a >= 18'h3C000) b = 3'd4;
      else                     b = {1'b0, a[17:16]};
    end else begin
      if (a < 18'h02000)       b = 3'd0;
      else if (a < 18'h03000)  b = 3'd1;
      else if (a < 18'h04000)  b = 3'd2;
      else if (a < 18'h10000)  b = 3'd3;
      else                     b = 3'd3 + {1'b0, a[17:16]};
    end
    return b;
  endfunction

  function automatic logic is_boot(input logic [ADDR_W-1:0] a, input bit top);
    return blk_of(a, top) == (top ? 3'd6 : 3'd0);
  endfunction
endpackage

// File: rtl/flash_we_edge.sv
module flash_we_edge (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_stb
);
  logic we_d;

  always_ff @(posedge clk) begin
    if (rst) we_d <= 1'b1;
    else     we_d <= we_n;
  end

  // Rising edge of write enable qualified by chip enable.
  assign wr_stb = ~we_d & we_n & ~ce_n;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp,
  input  logic              boot_unlock,
  input  logic              vpp_ok,
  input  logic              arr_busy,
  output logic              op_start,
  output logic              op_erase,
  output logic              arr_abort,
  output rd_mode_t          rd_mode,
  output logic [7:0]        status
);
  seq_t sq;
  logic err_erase, err_prog, err_vpp;
  logic run_boot, run_erase;
  logic tgt_boot, unlocked, accept, second_ok, armed;

  assign tgt_boot  = is_boot(addr, TOP_BOOT);
  assign unlocked  = wp | boot_unlock;
  assign accept    = wr_stb & ~arr_busy;
  assign armed     = (sq == SQ_ERASE_ARM) | (sq == SQ_PROG_ARM);
  assign second_ok = (sq == SQ_PROG_ARM) | ((sq == SQ_ERASE_ARM) & (din == CMD_CONFIRM));
  assign op_start  = accept & second_ok & vpp_ok & (~tgt_boot | unlocked);
  assign op_erase  = (sq == SQ_ERASE_ARM);
  assign arr_abort = arr_busy & (~vpp_ok | (run_boot & ~unlocked));
  assign status    = {~arr_busy, 1'b0, err_erase, err_prog, err_vpp, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      sq        <= SQ_IDLE;
      rd_mode   <= RD_ARRAY;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vpp   <= 1'b0;
      run_boot  <= 1'b0;
      run_erase <= 1'b0;
    end else begin
      if (arr_abort) begin
        if (run_erase) err_erase <= 1'b1;
        else           err_prog  <= 1'b1;
        if (!vpp_ok)   err_vpp   <= 1'b1;
      end
      if (accept && !armed) begin
        case (din)
          CMD_READ_ARRAY:  rd_mode <= RD_ARRAY;
          CMD_READ_STATUS: rd_mode <= RD_STATUS;
          CMD_READ_ID:     rd_mode <= RD_ID;
          CMD_CLEAR_ERR: begin
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_vpp   <= 1'b0;
          end
          CMD_ERASE_SETUP:     sq <= SQ_ERASE_ARM;
          CMD_PROG_A, CMD_PROG_B: sq <= SQ_PROG_ARM;
          default: ;
        endcase
      end else if (accept && armed) begin
        sq      <= SQ_IDLE;
        rd_mode <= RD_STATUS;
        if (!second_ok) begin
          err_erase <= 1'b1;
          err_prog  <= 1'b1;
        end else if (!vpp_ok || (tgt_boot && !unlocked)) begin
          if (!vpp_ok)  err_vpp   <= 1'b1;
          if (op_erase) err_erase <= 1'b1;
          else          err_prog  <= 1'b1;
        end else begin
          run_boot  <= tgt_boot;
          run_erase <= op_erase;
        end
      end
    end
  end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1,
  parameter int BUSY_CYC = 16,
  parameter int WIN_AW   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              abort,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int MEM_AW = 3 + WIN_AW;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int WIN    = 1 << WIN_AW;
  localparam int CW     = $clog2(BUSY_CYC + 1);

  function automatic logic [MEM_AW-1:0] fold(input logic [ADDR_W-1:0] a);
    return {blk_of(a, TOP_BOOT), a[WIN_AW-1:0]};
  endfunction

  logic [7:0]        mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic              op_er;
  logic [MEM_AW-1:0] op_idx;
  logic [7:0]        op_dat;

  // Behavioural model: the array powers up erased.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_er  <= 1'b0;
      op_idx <= '0;
      op_dat <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= CW'(BUSY_CYC - 1);
      op_er  <= erase;
      op_idx <= fold(addr);
      op_dat <= data;
    end else if (busy) begin
      if (abort) begin
        busy <= 1'b0;
      end else if (cnt == '0) begin
        busy <= 1'b0;
        if (op_er) begin
          for (int i = 0; i < WIN; i++)
            mem[{op_idx[MEM_AW-1:WIN_AW], WIN_AW'(i)}] <= 8'hFF;
        end else begin
          mem[op_idx] <= mem[op_idx] & op_dat;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign rd_data = mem[fold(rd_addr)];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter bit         TOP_BOOT   = 1'b1,
  parameter int         BUSY_CYC   = 16,
  parameter int         WIN_AW     = 5,
  parameter logic [7:0] MFR_ID     = 8'hA7,
  parameter logic [7:0] DEV_ID_TOP = 8'h4E,
  parameter logic [7:0] DEV_ID_BOT = 8'h4F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp,
  input  logic              boot_unlock,
  input  logic              vpp_ok,
  output logic [7:0]        dout,
  output logic              dout_en
);
  logic     wr_stb, op_start, op_erase, arr_abort, arr_busy, start_boot;
  rd_mode_t rd_mode;
  logic [7:0] status, arr_data, rd_sel;

  // Named event for the checker: the operation being started targets the boot block.
  assign start_boot = is_boot(addr, TOP_BOOT);

  flash_we_edge u_edge (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .wr_stb(wr_stb)
  );

  flash_cmd_seq #(.TOP_BOOT(TOP_BOOT)) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .din(din), .addr(addr),
    .wp(wp), .boot_unlock(boot_unlock), .vpp_ok(vpp_ok), .arr_busy(arr_busy),
    .op_start(op_start), .op_erase(op_erase), .arr_abort(arr_abort),
    .rd_mode(rd_mode), .status(status)
  );

  flash_array_model #(.TOP_BOOT(TOP_BOOT), .BUSY_CYC(BUSY_CYC), .WIN_AW(WIN_AW)) u_arr (
    .clk(clk), .rst(rst), .start(op_start), .erase(op_erase), .addr(addr),
    .data(din), .abort(arr_abort), .busy(arr_busy), .rd_addr(addr), .rd_data(arr_data)
  );

  always_comb begin
    if (arr_busy) rd_sel = status;
    else begin
      case (rd_mode)
        RD_ARRAY:  rd_sel = arr_data;
        RD_STATUS: rd_sel = status;
        default:   rd_sel = addr[0] ? (TOP_BOOT ? DEV_ID_TOP : DEV_ID_BOT) : MFR_ID;
      endcase
    end
  end

  assign dout_en = ~ce_n & ~oe_n & we_n;
  assign dout    = dout_en ? rd_sel : 8'h00;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int BUSY_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       wp,
  input logic       boot_unlock,
  input logic       vpp_ok,
  input logic       op_start,
  input logic       start_boot,
  input logic       arr_busy,
  input logic       arr_abort,
  input rd_mode_t   rd_mode,
  input logic [7:0] status
);
  logic [15:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !arr_busy) busy_run <= '0;
    else                  busy_run <= busy_run + 1'b1;
  end

  // R5: a boot-block start needs an unlock input
  a_r5_boot_start_unlocked: assert property (@(posedge clk) disable iff (rst)
    op_start && start_boot |-> (wp || boot_unlock));
  // R7: no start without supply
  a_r7_start_needs_vpp: assert property (@(posedge clk) disable iff (rst)
    op_start |-> vpp_ok);
  // R4: start leads to status mode, busy
  a_r4_start_to_status: assert property (@(posedge clk) disable iff (rst)
    op_start |=> (rd_mode == RD_STATUS) && !status[7]);
  // R4: busy window bounded
  a_r4_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 16'(BUSY_CYC));
  // R13: nothing starts during busy
  a_r13_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    arr_busy |-> !op_start);
  // R6: abort ends the operation with an error recorded
  a_r6_abort_flags: assert property (@(posedge clk) disable iff (rst)
    arr_abort |=> !arr_busy && (status[5] || status[4]));
  // R10: reset state
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (status == 8'h80) && (rd_mode == RD_ARRAY));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst(rst), .wp(wp), .boot_unlock(boot_unlock), .vpp_ok(vpp_ok),
  .op_start(op_start), .start_boot(start_boot), .arr_busy(arr_busy),
  .arr_abort(arr_abort), .rd_mode(rd_mode), .status(status)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int BUSY = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [17:0] addr = '0;
  logic wp = 1'b0, boot_unlock = 1'b0, vpp_ok = 1'b1;
  logic [7:0] dout;
  logic dout_en;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.BUSY_CYC(BUSY)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .din(din),
    .addr(addr), .wp(wp), .boot_unlock(boot_unlock), .vpp_ok(vpp_ok),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d, input logic ce = 1'b0);
    @(negedge clk); addr = a; din = d; ce_n = ce; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [17:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #2; d = dout; en = dout_en;
    #2; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rdchk(input string req, input logic [17:0] a, input logic [7:0] exp);
    logic [7:0] d; logic en;
    rd(a, d, en);
    check(req, d, exp);
  endtask

  task automatic wait_done();
    repeat (BUSY + 1) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic en;
    rd(18'h00005, d, en);
    check("R10 array mode after reset", d, 8'hFF);
    check("R14 dout_en on read", {7'b0, en}, 8'h01);
    wr(18'h0, 8'h70);
    rdchk("R11 status after reset", 18'h0, 8'h80);
    wr(18'h0, 8'hFF);
  endtask

  task automatic t_program();
    wr(18'h0, 8'h40); wr(18'h00005, 8'h3C);
    rdchk("R4 busy right after start", 18'h00005, 8'h00);
    repeat (BUSY - 3) @(negedge clk);
    rdchk("R4 busy at cycle BUSY_CYC-1", 18'h00005, 8'h00);
    rdchk("R4 ready at cycle BUSY_CYC", 18'h00005, 8'h80);
    rdchk("R3 status until FFh", 18'h00005, 8'h80);
    wr(18'h0, 8'hFF);
    rdchk("R2 programmed value", 18'h00005, 8'h3C);
    wr(18'h0, 8'h10); wr(18'h00005, 8'hF0); wait_done();
    wr(18'h0, 8'hFF);
    rdchk("R2 program ANDs", 18'h00005, 8'h30);
    wr(18'h0, 8'h40); wr(18'h10005, 8'h11); wait_done();
  endtask

  task automatic t_erase();
    wr(18'h0, 8'h20); wr(18'h00010, 8'hD0); wait_done();
    rdchk("R3 status after erase", 18'h0, 8'h80);
    wr(18'h0, 8'hFF);
    rdchk("R1 erased block", 18'h00005, 8'hFF);
    rdchk("R1 other block kept", 18'h10005, 8'h11);
  endtask

  task automatic t_boot_protect();
    wp = 1'b0; boot_unlock = 1'b0;
    wr(18'h0, 8'h40); wr(18'h3E003, 8'h00);
    rdchk("R5 program refused", 18'h0, 8'h90);
    wr(18'h0, 8'hFF);
    rdchk("R5 boot array unchanged", 18'h3E003, 8'hFF);
    wr(18'h0, 8'h70); wr(18'h0, 8'h50);
    rdchk("R11 clear errors", 18'h0, 8'h80);
    wr(18'h0, 8'h20); wr(18'h3E000, 8'hD0);
    rdchk("R5 erase refused", 18'h0, 8'hA0);
    wr(18'h0, 8'h50);
    wp = 1'b1;
    wr(18'h0, 8'h40); wr(18'h3F001, 8'h55); wait_done();
    wr(18'h0, 8'hFF);
    rdchk("R5 boot program with wp", 18'h3F001, 8'h55);
    wp = 1'b0; boot_unlock = 1'b1;
    wr(18'h0, 8'h20); wr(18'h3F000, 8'hD0); wait_done();
    wr(18'h0, 8'hFF);
    rdchk("R5 boot erase with unlock", 18'h3F001, 8'hFF);
    boot_unlock = 1'b0;
  endtask

  task automatic t_map();
    wr(18'h0, 8'h40); wr(18'h3DFFF, 8'h5A); wait_done();
    rdchk("R9 parameter block needs no unlock", 18'h0, 8'h80);
    wr(18'h0, 8'h40); wr(18'h3BFFF, 8'h0F); wait_done();
    wr(18'h0, 8'h40); wr(18'h3C000, 8'h0F); wait_done();
    wr(18'h0, 8'h20); wr(18'h3C010, 8'hD0); wait_done();
    wr(18'h0, 8'hFF);
    rdchk("R9 top param block data", 18'h3DFFF, 8'h5A);
    rdchk("R9 3C000 erased", 18'h3C000, 8'hFF);
    rdchk("R9 3BFFF in other block", 18'h3BFFF, 8'h0F);
  endtask

  task automatic t_abort();
    wp = 1'b1;
    wr(18'h0, 8'h40); wr(18'h3E004, 8'h00);
    repeat (2) @(negedge clk);
    wp = 1'b0;
    rdchk("R6 aborted status", 18'h0, 8'h90);
    wr(18'h0, 8'h50); wr(18'h0, 8'hFF);
    rdchk("R6 array unchanged", 18'h3E004, 8'hFF);
  endtask

  task automatic t_vpp();
    vpp_ok = 1'b0;
    wr(18'h0, 8'h40); wr(18'h20007, 8'h00);
    rdchk("R7 program refused low vpp", 18'h0, 8'h98);
    wr(18'h0, 8'h50);
    vpp_ok = 1'b1;
    wr(18'h0, 8'h40); wr(18'h20007, 8'h12); wait_done();
    wr(18'h0, 8'h20); wr(18'h20000, 8'hD0);
    repeat (2) @(negedge clk);
    vpp_ok = 1'b0;
    rdchk("R7 erase aborted by vpp", 18'h0, 8'hA8);
    vpp_ok = 1'b1;
    wr(18'h0, 8'h50); wr(18'h0, 8'hFF);
    rdchk("R7 block not erased", 18'h20007, 8'h12);
  endtask

  task automatic t_bad_seq();
    wr(18'h0, 8'h20); wr(18'h20000, 8'h77);
    rdchk("R8 bad confirm status", 18'h20007, 8'hB0);
    wr(18'h0, 8'hFF);
    rdchk("R8 nothing erased", 18'h20007, 8'h12);
    wr(18'h0, 8'h70); wr(18'h0, 8'h50);
  endtask

  task automatic t_id();
    wr(18'h0, 8'h90);
    rdchk("R12 manufacturer code", 18'h00000, 8'hA7);
    rdchk("R12 device code top", 18'h00001, 8'h4E);
    wr(18'h0, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    wr(18'h0, 8'h40); wr(18'h10005, 8'hF0);
    wr(18'h0, 8'hFF); wr(18'h0, 8'h90);
    wait_done();
    rdchk("R13 commands during busy ignored", 18'h00001, 8'h80);
    wr(18'h0, 8'hFF);
    rdchk("R13 program completed", 18'h10005, 8'h10);
  endtask

  task automatic t_ce_gate();
    wr(18'h0, 8'h70);
    wr(18'h0, 8'hFF, 1'b1);
    rdchk("R14 write with ce_n high ignored", 18'h10005, 8'h80);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    #2;
    check("R14 dout_en low with oe_n high", {7'b0, dout_en}, 8'h00);
    check("R14 dout zero when not enabled", dout, 8'h00);
    #2; ce_n = 1'b1;
    wr(18'h0, 8'hFF);
  endtask

  task automatic t_reset_mid();
    wr(18'h0, 8'h20); wr(18'h0, 8'h77);
    rdchk("R8 error before reset", 18'h0, 8'hB0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rdchk("R10 array mode after reset", 18'h10005, 8'h10);
    wr(18'h0, 8'h70);
    rdchk("R10 errors cleared by reset", 18'h0, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_program();
    t_erase();
    t_boot_protect();
    t_map();
    t_abort();
    t_vpp();
    t_bad_seq();
    t_id();
    t_busy_ignore();
    t_ce_gate();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule